// File: doc/BRIEF.md
# Multiplexed LCD Segment Phase Driver

This block drives a segment LCD panel with twenty segment lines and four common (backplane) lines at the logic level. Each segment keeps one storage bit per display phase. A CPU writes these bits one nibble at a time through a small address space: bit 0 of the nibble feeds phase 1, and bit 3 feeds phase 4. A sequencer steps through the phases at a rate taken from a free-running prescaler. In phase k it drives common line k high and puts every segment's phase-k bit on that segment's line.

The sequencer is a state machine with five states. `ST_DARK` is the display-off state. `ST_PH1` to `ST_PH4` are the four phases. The transitions are:
- `ST_DARK` goes to `ST_PH1` once the off flag clears.
- On each prescaler tick, `ST_PH1` goes to `ST_PH2`, and `ST_PH2` goes to `ST_PH3`.
- On a tick, `ST_PH3` goes to `ST_PH4` in four-phase mode and back to `ST_PH1` in three-phase mode.
- On a tick, `ST_PH4` goes to `ST_PH1`.
- Any phase state goes to `ST_DARK` when the off flag sets.
- Any phase state goes to `ST_PH1` when a write changes the multiplex mode.

A blank flag forces the segment lines low and leaves the common lines running. Two flags, an external-supply enable and a 2-bit strobe select, are only stored and read back. Power-on reset clears them; ordinary reset does not.

Top module: `lcd_phase_drv`

## Requirements
- R1: After reset, `com` and `seg` are all zero. Address 21 reads 4'b0111: bit0 off=1, bit1 blank=1, bit2 four-phase=1, bit3 external supply=0. Address 20 reads 0: bits 1:0 rate select, bits 3:2 strobe select.
- R2: A write to address n (0..19) stores the nibble for segment n, and a read of n returns it. Addresses 22..31 read 0, and writes to them change no stored value.
- R3: Whenever the display is on, exactly one common line is high: `com[k-1]` in phase k.
- R4: In phase k, with blank clear, `seg[n]` equals bit k-1 of the nibble stored at address n.
- R5: In four-phase mode the phases follow the order 1,2,3,4,1. Phase 2 is entered only from phase 1.
- R6: In three-phase mode (bit2 of address 21 = 0) the order is 1,2,3,1, and `com[3]` stays low.
- R7: Rate select s (0..3) makes every phase last 64·2^s clock cycles.
- R8: While off (bit0 of address 21 = 1), `com` and `seg` are all zero. Clearing off starts the sequence at phase 1 on the second clock edge after the write.
- R9: Blank (bit1 of address 21 = 1) forces `seg` to zero while `com` keeps cycling.
- R10: A write that changes the four-phase bit puts the sequencer in phase 1 on that same clock edge.
- R11: Ordinary reset keeps the external-supply bit and the strobe select. Power-on reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the prescaler counts it |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | Ordinary reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Register address |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Read data for `addr` |
| com | output | 4 | Common (backplane) lines, one-hot |
| seg | output | 20 | Segment lines |

## Verification
The bench watches mode changes that land in the middle of a frame. If a switch to three-phase mode came during phase 2 or phase 4 and the sequencer waited for the frame to end, a stale fourth phase would be emitted; the bench catches that as a late phase-1 restart or a visible `com[3]`.

Rate changes are measured as whole phase lengths, so a tap decoded off by one shows up as a period that is half or double the expected one.

A reset-domain mix-up shows up in the read values after each kind of reset: ordinary reset must keep the supply and strobe bits, and power-on reset must clear them. The bench also checks that writes to unmapped addresses leave the stored values intact.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
    localparam int NIB_W = 4;
    typedef enum logic [2:0] {
        ST_DARK = 3'd0,
        ST_PH1  = 3'd1,
        ST_PH2  = 3'd2,
        ST_PH3  = 3'd3,
        ST_PH4  = 3'd4
    } phase_e;
endpackage

// File: rtl/lcd_regs.sv
module lcd_regs
    import lcd_drv_pkg::*;
#(
    parameter int NUM_SEG = 20,
    parameter int ADDR_W  = 5
) (
    input  logic                     clk,
    input  logic                     sys_rst_n,
    input  logic                     por_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NIB_W-1:0]         wdata,
    output logic [NIB_W-1:0]         rdata,
    output logic [NUM_SEG*NIB_W-1:0] latch_flat,
    output logic [1:0]               tap_sel,
    output logic                     lcd_off,
    output logic                     lcd_blank,
    output logic                     mux4,
    output logic                     mode_chg
);
    localparam logic [ADDR_W-1:0] ADDR_RATE = ADDR_W'(NUM_SEG);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_SEG + 1);

    logic [NIB_W-1:0] lat [NUM_SEG];
    logic [1:0]       strobe_sel;
    logic             ext_sup;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEG; gi++) begin : g_seg
            always_ff @(posedge clk or negedge sys_rst_n) begin
                if (!sys_rst_n)
                    lat[gi] <= '0;
                else if (wr_en && addr == ADDR_W'(gi))
                    lat[gi] <= wdata;
            end
            assign latch_flat[gi*NIB_W +: NIB_W] = lat[gi];
        end
    endgenerate

    // control flags on the ordinary reset
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            tap_sel   <= 2'b00;
            lcd_off   <= 1'b1;
            lcd_blank <= 1'b1;
            mux4      <= 1'b1;
        end else if (wr_en) begin
            if (addr == ADDR_RATE)
                tap_sel <= wdata[1:0];
            if (addr == ADDR_CTRL) begin
                lcd_off   <= wdata[0];
                lcd_blank <= wdata[1];
                mux4      <= wdata[2];
            end
        end
    end

    // flags cleared by power-on only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            strobe_sel <= 2'b00;
            ext_sup    <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_RATE)
                strobe_sel <= wdata[3:2];
            if (addr == ADDR_CTRL)
                ext_sup <= wdata[3];
        end
    end

    assign mode_chg = wr_en && (addr == ADDR_CTRL) && (wdata[2] != mux4);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SEG; i++)
            if (addr == ADDR_W'(i))
                rdata = lat[i];
        if (addr == ADDR_RATE)
            rdata = {strobe_sel, tap_sel};
        if (addr == ADDR_CTRL)
            rdata = {ext_sup, mux4, lcd_blank, lcd_off};
    end
endmodule

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
    parameter int BASE_LOG2 = 6,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;
    logic [CW-1:0] one_v;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)
            cnt <= '0;
        else
            cnt <= cnt + one_v;
    end

    always_comb begin
        one_v = CW'(1);
        mask  = (one_v << (BASE_LOG2 + 32'(sel))) - one_v;
        tick  = ((cnt & mask) == mask);
    end
endmodule

// File: rtl/lcd_phase_fsm.sv
module lcd_phase_fsm
    import lcd_drv_pkg::*;
(
    input  logic       clk,
    input  logic       sys_rst_n,
    input  logic       tick,
    input  logic       lcd_off,
    input  logic       mux4,
    input  logic       mode_chg,
    output logic [3:0] com,
    output logic [1:0] ph_idx,
    output logic       ph_live
);
    phase_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DARK: if (!lcd_off) state_nx = ST_PH1;
            ST_PH1, ST_PH2, ST_PH3, ST_PH4: begin
                if (lcd_off)
                    state_nx = ST_DARK;
                else if (mode_chg)
                    state_nx = ST_PH1;
                else if (tick) begin
                    unique case (state)
                        ST_PH1:  state_nx = ST_PH2;
                        ST_PH2:  state_nx = ST_PH3;
                        ST_PH3:  state_nx = mux4 ? ST_PH4 : ST_PH1;
                        default: state_nx = ST_PH1;
                    endcase
                end
            end
            default: state_nx = ST_DARK;
        endcase
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)
            state <= ST_DARK;
        else
            state <= state_nx;
    end

    always_comb begin
        com     = 4'b0000;
        ph_idx  = 2'd0;
        ph_live = 1'b0;
        unique case (state)
            ST_DARK: ;
            ST_PH1: begin com = 4'b0001; ph_idx = 2'd0; ph_live = 1'b1; end
            ST_PH2: begin com = 4'b0010; ph_idx = 2'd1; ph_live = 1'b1; end
            ST_PH3: begin com = 4'b0100; ph_idx = 2'd2; ph_live = 1'b1; end
            ST_PH4: begin com = 4'b1000; ph_idx = 2'd3; ph_live = 1'b1; end
            default: ;
        endcase
        if (lcd_off) begin
            com     = 4'b0000;
            ph_live = 1'b0;
        end
    end
endmodule

// File: rtl/lcd_phase_drv.sv
module lcd_phase_drv
    import lcd_drv_pkg::*;
#(
    parameter int NUM_SEG   = 20,
    parameter int ADDR_W    = 5,
    parameter int BASE_LOG2 = 6
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [3:0]         wdata,
    output logic [3:0]         rdata,
    output logic [3:0]         com,
    output logic [NUM_SEG-1:0] seg
);
    logic                     sys_rst_n;
    logic [NUM_SEG*NIB_W-1:0] latch_flat;
    logic [1:0]               tap_sel;
    logic                     lcd_off, lcd_blank, mux4, mode_chg;
    logic                     tick, ph_live;
    logic [1:0]               ph_idx;

    assign sys_rst_n = por_n & rst_n;

    lcd_regs #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .sys_rst_n(sys_rst_n), .por_n(por_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .latch_flat(latch_flat), .tap_sel(tap_sel),
        .lcd_off(lcd_off), .lcd_blank(lcd_blank), .mux4(mux4),
        .mode_chg(mode_chg)
    );

    lcd_tick_gen #(.BASE_LOG2(BASE_LOG2), .SEL_W(2)) u_tick (
        .clk(clk), .sys_rst_n(sys_rst_n), .sel(tap_sel), .tick(tick)
    );

    lcd_phase_fsm u_fsm (
        .clk(clk), .sys_rst_n(sys_rst_n), .tick(tick),
        .lcd_off(lcd_off), .mux4(mux4), .mode_chg(mode_chg),
        .com(com), .ph_idx(ph_idx), .ph_live(ph_live)
    );

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SEG; gs++) begin : g_out
            assign seg[gs] = ph_live && !lcd_blank &&
                             latch_flat[gs*NIB_W + 32'(ph_idx)];
        end
    endgenerate
endmodule

// File: rtl/lcd_drv_checker.sv
module lcd_drv_checker #(
    parameter int NUM_SEG = 20
) (
    input logic               clk,
    input logic               sys_rst_n,
    input logic [3:0]         com,
    input logic [NUM_SEG-1:0] seg,
    input logic               lcd_off,
    input logic               lcd_blank,
    input logic               mux4
);
    p_com_onehot_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $onehot0(com));

    p_dark_quiet_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        lcd_off |-> (com == 4'b0000 && seg == '0));

    p_blank_seg_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        lcd_blank |-> (seg == '0));

    p_no_com4_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !mux4 |-> !com[3]);

    p_ph2_after_ph1_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(com[1]) |-> $past(com[0]));
endmodule

bind lcd_phase_drv lcd_drv_checker #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk(clk), .sys_rst_n(sys_rst_n), .com(com), .seg(seg),
    .lcd_off(lcd_off), .lcd_blank(lcd_blank), .mux4(mux4)
);

// File: tb/test_lcd_phase_drv.sv
`timescale 1ns/1ps
module test_lcd_phase_drv;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [3:0]  wdata = '0;
    logic [3:0]  rdata, com;
    logic [19:0] seg;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    lcd_phase_drv i_lcd_phase_drv (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .com(com), .seg(seg)
    );

    // {addr, write data, expected read}
    localparam logic [12:0] VEC [8] = '{
        {5'd0,  4'hA, 4'hA}, {5'd1,  4'h5, 4'h5}, {5'd19, 4'hC, 4'hC},
        {5'd7,  4'h3, 4'h3}, {5'd24, 4'hF, 4'h0}, {5'd31, 4'h9, 4'h0},
        {5'd12, 4'h0, 4'h0}, {5'd5,  4'hF, 4'hF}
    };

    function automatic logic [3:0] pat(int n);
        return 4'((n * 7 + 3) % 16);
    endfunction

    function automatic int ph_of(logic [3:0] c);
        case (c)
            4'b0001: return 1;
            4'b0010: return 2;
            4'b0100: return 3;
            4'b1000: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [3:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_change(output int ph);
        logic [3:0] c0;
        c0 = com;
        do @(negedge clk); while (com == c0);
        ph = ph_of(com);
    endtask

    task automatic wait_phase(int k);
        while (ph_of(com) != k) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [3:0] d;
        int ph, prev, n;
        logic [19:0] exp_seg;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 com", com, 0);
        chk("R1 seg", seg, 0);
        rd(5'd21, d); chk("R1 ctrl", d, 4'b0111);
        rd(5'd20, d); chk("R1 rate", d, 0);

        // R2 vector walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][12:8], VEC[i][7:4]);
            rd(VEC[i][12:8], d);
            chk("R2 readback", d, VEC[i][3:0]);
        end
        wr(5'd22, 4'hF);
        rd(5'd21, d); chk("R2 ignored write ctrl", d, 4'b0111);
        rd(5'd20, d); chk("R2 ignored write rate", d, 0);
        rd(5'd0, d);  chk("R2 ignored write seg0", d, 4'hA);

        for (int s = 0; s < 20; s++) wr(5'(s), pat(s));

        // R8 restart at phase 1 after enabling
        wr(5'd21, 4'b0100);
        @(negedge clk);
        chk("R8 restart phase1", com, 4'b0001);

        // R4 segment data per phase, R3 one-hot
        for (int k = 1; k <= 4; k++) begin
            wait_phase(k);
            for (int s = 0; s < 20; s++) exp_seg[s] = pat(s)[k-1];
            chk("R4 seg", seg, exp_seg);
            chk("R3 com", com, 1 << (k - 1));
        end

        // R5 four-phase order
        wait_change(prev);
        for (int i = 0; i < 6; i++) begin
            wait_change(ph);
            chk("R5 order", ph, prev % 4 + 1);
            prev = ph;
        end

        // R7 rate select
        for (int s = 0; s < 4; s++) begin
            wr(5'd20, 4'(s));
            wait_change(ph);
            n = 0;
            d = com;
            do begin @(negedge clk); n++; end while (com == d);
            chk("R7 period", n, 64 << s);
        end
        wr(5'd20, 4'd0);

        // R9 blank
        wr(5'd21, 4'b0110);
        chk("R9 seg blank", seg, 0);
        chk("R9 com alive", (com != 0), 1);
        wait_change(ph);
        chk("R9 com cycles", (ph != 0), 1);
        wr(5'd21, 4'b0100);

        // R10 + R6 three-phase mode
        wait_phase(2);
        wr(5'd21, 4'b0000);
        chk("R10 to three-phase", com, 4'b0001);
        prev = 1;
        for (int i = 0; i < 9; i++) begin
            wait_change(ph);
            chk("R6 order", ph, prev % 3 + 1);
            prev = ph;
        end
        wait_phase(2);
        wr(5'd21, 4'b0100);
        chk("R10 to four-phase", com, 4'b0001);

        // R8 off
        wr(5'd21, 4'b0101);
        chk("R8 com off", com, 0);
        chk("R8 seg off", seg, 0);
        repeat (200) @(negedge clk);
        chk("R8 stays off", {com, seg}, 0);
        wr(5'd21, 4'b0100);
        chk("R8 dark one cycle", com, 0);
        @(negedge clk);
        chk("R8 phase1", com, 4'b0001);

        // R11 reset domains
        wr(5'd21, 4'b1100);
        wr(5'd20, 4'b1011);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(5'd21, d); chk("R11 ctrl after rst", d, 4'b1111);
        rd(5'd20, d); chk("R11 rate after rst", d, 4'b1000);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(5'd21, d); chk("R11 ctrl after por", d, 4'b0111);
        rd(5'd20, d); chk("R11 rate after por", d, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule